// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a parameterized chain of boundary scan cells that sits between a chip's core logic and its pads. Each pin has one data cell, and each bidirectional pin also has a direction cell. Every cell has a shift-stage flop and an update-stage flop. An external test access port controller supplies the test clock, serial input, capture, shift and update strobes, and two decoded instruction selects: one for observe/preload and one for external test.

With the observe/preload instruction, a capture takes a snapshot of every pin into the shift stage. The snapshot is moved out serially while new data is moved in, and an update copies the shift stage into the update stage. The pins keep following the core throughout. With the external test instruction, output and bidirectional pins are driven from the update stage instead of the core, and a capture records only the values that arrive at the pads. When neither select is active, the chain ignores every strobe.

The pin kinds come from a per-pin type vector, and the chain length follows from that vector.

Top module: `bscan_chain`

## Requirements
- R1: With `sel_sample`=1, a rising `tck` with `capture_dr`=1 loads each data cell as follows: an input pin loads `pin_in`, an output pin loads the driven `pin_out` value (`core_out`), and a bidirectional pin loads `pin_in`. Each direction cell loads that pin's present `pin_oe`.
- R2: With `sel_extest`=1, a capture loads the data cells of input and bidirectional pins from `pin_in`. The data cells of output pins and all direction cells keep their previous value.
- R3: With a select active and `shift_dr`=1, each rising `tck` moves the chain one cell toward cell 0, and `tdi` enters the highest cell. `tdo` is cell 0 at all times. Capture has priority over shift.
- R4: The update stage loads the whole shift stage on the falling edge of `tck` when `update_dr`=1 and a select is active, and holds otherwise. A synchronous `rst` clears both stages.
- R5: With `sel_extest`=1, each output pin drives its update-stage data bit with `pin_oe`=1. Each bidirectional pin drives its update-stage data bit with `pin_oe` equal to its direction cell's update bit (1 means drive). Each input pin has `pin_oe`=0.
- R6: With `sel_extest`=0, output and bidirectional pins carry `core_out`. `pin_oe` is 1 for output pins, `core_oe` for bidirectional pins and 0 for input pins, where `pin_out` is 0. This holds whatever the update stage contains.
- R7: `core_in` equals `pin_in` for every pin under every instruction.
- R8: With both selects at 0, the capture, shift and update strobes change neither stage.
- R9: `PIN_KIND` holds two bits per pin, with pin p at bits [2p+1:2p]: 00 input, 01 output, 10 bidirectional. Cells 0 to NUM_PINS-1 are the data cells of pins 0 upward. The direction cells of the bidirectional pins follow in ascending pin order. The chain length is NUM_PINS plus the number of bidirectional pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset of both stages |
| tdi | input | 1 | Serial scan input into the highest cell |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| sel_sample | input | 1 | Observe/preload instruction is current |
| sel_extest | input | 1 | External test instruction is current |
| core_out | input | NUM_PINS | Values the core wants on the pins |
| core_oe | input | NUM_PINS | Core output enables for bidirectional pins |
| pin_in | input | NUM_PINS | Values seen at the pads |
| pin_out | output | NUM_PINS | Values driven toward the pads |
| pin_oe | output | NUM_PINS | Pad output enables |
| core_in | output | NUM_PINS | Pad values passed to the core |
| tdo | output | 1 | Serial scan output, cell 0 |

## Verification
The main round trip of capture, scan and update runs under observe/preload with five pin and core patterns: all zeros, all ones, and three mixed patterns. In the mixed patterns, `pin_in` and `core_out` differ on the output pin. This separates a capture of the driven value from a capture of the pad, and it shows whether each direction cell records the enable and not the data. Each pattern preloads a distinct word that is then applied under external test, which shows the data/direction cell mapping at the pins. Directed cases apply the external-test capture with a known word in the chain, to show which cells hold. They also pulse every strobe with no select active, and probe the pins on both sides of the falling edge during an update.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

    localparam int MAX_PINS = 256;

    typedef enum logic [1:0] {
        KIND_IN    = 2'b00,
        KIND_OUT   = 2'b01,
        KIND_BIDIR = 2'b10
    } pin_kind_e;

    // strobes and selects as seen by the cell stages
    typedef struct packed {
        logic active;
        logic extest;
        logic capture;
        logic shift;
        logic update;
    } bs_ctl_t;

    function automatic pin_kind_e kind_of(input logic [2*MAX_PINS-1:0] kinds, input int idx);
        return pin_kind_e'(kinds[2*idx +: 2]);
    endfunction

    // number of bidirectional pins with index below n
    function automatic int bidir_below(input logic [2*MAX_PINS-1:0] kinds, input int n);
        int c = 0;
        for (int i = 0; i < n; i++)
            if (kinds[2*i +: 2] == 2'b10) c++;
        return c;
    endfunction

    // pins whose pin_out carries core_out outside external test
    function automatic logic [MAX_PINS-1:0] drive_mask(input logic [2*MAX_PINS-1:0] kinds, input int n);
        logic [MAX_PINS-1:0] m = '0;
        for (int i = 0; i < n; i++)
            m[i] = (kinds[2*i +: 2] != 2'b00);
        return m;
    endfunction

endpackage

// File: rtl/bscan_shift_stage.sv
`timescale 1ns/1ps
module bscan_shift_stage import bscan_pkg::*; #(
    parameter int CHAIN_LEN = 6
) (
    input  logic                 tck,
    input  logic                 rst,
    input  bs_ctl_t              ctl,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-1:0] cap_val,
    input  logic [CHAIN_LEN-1:0] cap_load,
    output logic [CHAIN_LEN-1:0] sh_q,
    output logic                 tdo
);

    logic unused_ctl;
    assign unused_ctl = ctl.update;

    always_ff @(posedge tck) begin
        if (rst)
            sh_q <= '0;
        else if (ctl.active && ctl.capture)
            sh_q <= (sh_q & ~cap_load) | (cap_val & cap_load);
        else if (ctl.active && ctl.shift)
            sh_q <= {tdi, sh_q[CHAIN_LEN-1:1]};
    end

    assign tdo = sh_q[0];

    AST_SHIFT_MOVES: assert property (@(posedge tck) disable iff (rst)
        (ctl.active && ctl.shift && !ctl.capture)
        |=> (sh_q[CHAIN_LEN-2:0] == $past(sh_q[CHAIN_LEN-1:1])) && (sh_q[CHAIN_LEN-1] == $past(tdi))); // R3

    AST_EXTEST_HOLD: assert property (@(posedge tck) disable iff (rst)
        (ctl.active && ctl.extest && ctl.capture)
        |=> (((sh_q ^ $past(sh_q)) & ~$past(cap_load)) == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (rst)
        !ctl.active |=> $stable(sh_q)); // R8

endmodule

// File: rtl/bscan_update_stage.sv
`timescale 1ns/1ps
module bscan_update_stage import bscan_pkg::*; #(
    parameter int CHAIN_LEN = 6
) (
    input  logic                 tck,
    input  logic                 rst,
    input  bs_ctl_t              ctl,
    input  logic [CHAIN_LEN-1:0] sh_q,
    output logic [CHAIN_LEN-1:0] upd_q
);

    logic unused_ctl;
    assign unused_ctl = ^{ctl.extest, ctl.capture, ctl.shift};

    // falling-edge load keeps pin changes clear of the rising-edge strobes
    always_ff @(negedge tck) begin
        if (rst)
            upd_q <= '0;
        else if (ctl.active && ctl.update)
            upd_q <= sh_q;
    end

    AST_UPD_GATED: assert property (@(negedge tck) disable iff (rst)
        !$stable(upd_q) |-> ($past(ctl.active && ctl.update) || $past(rst))); // R4

endmodule

// File: rtl/bscan_pin_cells.sv
`timescale 1ns/1ps
module bscan_pin_cells import bscan_pkg::*; #(
    parameter int                     NUM_PINS  = 4,
    parameter logic [2*MAX_PINS-1:0]  KINDS     = '0,
    parameter int                     CHAIN_LEN = 6
) (
    input  logic                 extest,
    input  logic [CHAIN_LEN-1:0] upd_q,
    input  logic [NUM_PINS-1:0]  core_out,
    input  logic [NUM_PINS-1:0]  core_oe,
    input  logic [NUM_PINS-1:0]  pin_in,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic [NUM_PINS-1:0]  core_in,
    output logic [CHAIN_LEN-1:0] cap_val,
    output logic [CHAIN_LEN-1:0] cap_load
);

    logic unused_sink;
    assign unused_sink = ^{core_oe, upd_q};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam pin_kind_e K = kind_of(KINDS, p);
        assign core_in[p] = pin_in[p];

        if (K == KIND_BIDIR) begin : g_bidir
            localparam int CI = NUM_PINS + bidir_below(KINDS, p);
            assign pin_out[p]   = extest ? upd_q[p]  : core_out[p];
            assign pin_oe[p]    = extest ? upd_q[CI] : core_oe[p];
            assign cap_val[p]   = pin_in[p];
            assign cap_load[p]  = 1'b1;
            assign cap_val[CI]  = pin_oe[p];
            assign cap_load[CI] = !extest;
        end else if (K == KIND_OUT) begin : g_out
            assign pin_out[p]  = extest ? upd_q[p] : core_out[p];
            assign pin_oe[p]   = 1'b1;
            assign cap_val[p]  = pin_out[p];
            assign cap_load[p] = !extest;
        end else begin : g_in
            assign pin_out[p]  = 1'b0;
            assign pin_oe[p]   = 1'b0;
            assign cap_val[p]  = pin_in[p];
            assign cap_load[p] = 1'b1;
        end
    end

endmodule

// File: rtl/bscan_chain.sv
`timescale 1ns/1ps
module bscan_chain import bscan_pkg::*; #(
    parameter int                    NUM_PINS = 4,
    parameter logic [2*NUM_PINS-1:0] PIN_KIND = 8'b10_10_01_00
) (
    input  logic                tck,
    input  logic                rst,
    input  logic                tdi,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                sel_sample,
    input  logic                sel_extest,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] core_in,
    output logic                tdo
);

    localparam logic [2*MAX_PINS-1:0] KINDS     = (2*MAX_PINS)'(PIN_KIND);
    localparam int                    NUM_BIDIR = bidir_below(KINDS, NUM_PINS);
    localparam int                    CHAIN_LEN = NUM_PINS + NUM_BIDIR;
    localparam logic [MAX_PINS-1:0]   DRV_ALL   = drive_mask(KINDS, NUM_PINS);
    localparam logic [NUM_PINS-1:0]   DRV_MASK  = DRV_ALL[NUM_PINS-1:0];

    bs_ctl_t              ctl;
    logic [CHAIN_LEN-1:0] sh_q, upd_q, cap_val, cap_load;

    assign ctl.active  = sel_sample | sel_extest;
    assign ctl.extest  = sel_extest;
    assign ctl.capture = capture_dr;
    assign ctl.shift   = shift_dr;
    assign ctl.update  = update_dr;

    bscan_pin_cells #(.NUM_PINS(NUM_PINS), .KINDS(KINDS), .CHAIN_LEN(CHAIN_LEN)) pins_i (
        .extest(sel_extest), .upd_q(upd_q), .core_out(core_out), .core_oe(core_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in),
        .cap_val(cap_val), .cap_load(cap_load)
    );

    bscan_shift_stage #(.CHAIN_LEN(CHAIN_LEN)) shift_i (
        .tck(tck), .rst(rst), .ctl(ctl), .tdi(tdi), .cap_val(cap_val),
        .cap_load(cap_load), .sh_q(sh_q), .tdo(tdo)
    );

    bscan_update_stage #(.CHAIN_LEN(CHAIN_LEN)) update_i (
        .tck(tck), .rst(rst), .ctl(ctl), .sh_q(sh_q), .upd_q(upd_q)
    );

    AST_PASS_THROUGH: assert property (@(posedge tck) disable iff (rst)
        !sel_extest |-> (((pin_out ^ core_out) & DRV_MASK) == '0)); // R6

    AST_CORE_IN: assert property (@(posedge tck) disable iff (rst)
        core_in == pin_in); // R7

    AST_IN_NEVER_DRIVEN: assert property (@(posedge tck) disable iff (rst)
        (pin_oe & ~DRV_MASK) == '0); // R5

endmodule

// File: tb/bscan_chain_tb.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;

    logic       clk = 1'b0;
    logic       rst, tdi, cap, shf, upd, s_smp, s_ext;
    logic [3:0] core_out, core_oe, pin_in, pin_out, pin_oe, core_in;
    logic       tdo;
    int         checks = 0, failures = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    bscan_chain dut_i (
        .tck(clk), .rst(rst), .tdi(tdi), .capture_dr(cap), .shift_dr(shf),
        .update_dr(upd), .sel_sample(s_smp), .sel_extest(s_ext),
        .core_out(core_out), .core_oe(core_oe), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in), .tdo(tdo)
    );

    // fields: pin_in[23:20] core_out[19:16] core_oe[15:12] scan_in[11:6] expected_capture[5:0]
    localparam logic [23:0] VEC [5] = '{
        {4'b0000, 4'b0000, 4'b0000, 6'b111111, 6'b000000},
        {4'b1111, 4'b1111, 4'b1100, 6'b000000, 6'b111111},
        {4'b0101, 4'b0010, 4'b0100, 6'b101010, 6'b010111},
        {4'b1010, 4'b1101, 4'b1000, 6'b010101, 6'b101000},
        {4'b1001, 4'b0110, 4'b0000, 6'b110011, 6'b001011}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_capture();
        @(posedge clk); #2 cap = 1'b1;
        @(posedge clk); #2 cap = 1'b0;
    endtask

    task automatic do_update();
        @(posedge clk); #2 upd = 1'b1;
        @(posedge clk); #2 upd = 1'b0;
    endtask

    task automatic scan(input logic [5:0] si, output logic [5:0] so);
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #2;
            so[k] = tdo;
            tdi = si[k];
            shf = 1'b1;
        end
        @(posedge clk); #2 shf = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [5:0] so, si, ex;
        logic [3:0] pi, co, oe;
        rst = 1'b1; tdi = 1'b0; cap = 1'b0; shf = 1'b0; upd = 1'b0;
        s_smp = 1'b0; s_ext = 1'b1;
        core_out = 4'b1111; core_oe = 4'b1111; pin_in = 4'b0000;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #1;
        // R4: cleared update stage under external test
        chk("R4 reset pin_out", {4'b0, pin_out}, 8'b0000_0000);
        chk("R4 reset pin_oe",  {4'b0, pin_oe},  8'b0000_0010);
        chk("R4 reset tdo",     {7'b0, tdo},     8'b0);

        for (int v = 0; v < 5; v++) begin
            pi = VEC[v][23:20]; co = VEC[v][19:16]; oe = VEC[v][15:12];
            si = VEC[v][11:6];  ex = VEC[v][5:0];
            pin_in = pi; core_out = co; core_oe = oe;
            @(posedge clk); #2 s_ext = 1'b0; s_smp = 1'b1;
            do_capture();
            scan(si, so);
            chk($sformatf("R1 R3 R9 capture vec%0d", v), {2'b0, so}, {2'b0, ex});
            do_update();
            #1;
            chk($sformatf("R6 pins follow core vec%0d", v), {pin_oe, pin_out},
                {oe[3], oe[2], 1'b1, 1'b0, co[3], co[2], co[1], 1'b0});
            chk($sformatf("R7 core_in vec%0d", v), {4'b0, core_in}, {4'b0, pi});
            @(posedge clk); #2 s_smp = 1'b0; s_ext = 1'b1;
            #1;
            chk($sformatf("R5 extest pins vec%0d", v), {pin_oe, pin_out},
                {si[5], si[4], 1'b1, 1'b0, si[3], si[2], si[1], 1'b0});
        end

        // R2: external test capture keeps output and direction cells
        @(posedge clk); #2 s_ext = 1'b0; s_smp = 1'b1;
        scan(6'b111111, so);
        @(posedge clk); #2 s_smp = 1'b0; s_ext = 1'b1; pin_in = 4'b0000;
        do_capture();
        scan(6'b000000, so);
        chk("R2 extest capture", {2'b0, so}, 8'b0011_0010);

        // R8: strobes with no select active
        @(posedge clk); #2 s_ext = 1'b0; s_smp = 1'b1;
        scan(6'b100110, so);
        do_update();
        @(posedge clk); #2 s_smp = 1'b0; pin_in = 4'b1111;
        do_capture();
        scan(6'b000000, so);
        do_update();
        @(posedge clk); #2 s_smp = 1'b1;
        scan(6'b000000, so);
        chk("R8 shift stage untouched", {2'b0, so}, 8'b0010_0110);
        @(posedge clk); #2 s_smp = 1'b0; s_ext = 1'b1;
        #1;
        chk("R8 update stage untouched", {pin_oe, pin_out}, 8'b1010_0110);

        // R4: update lands on the falling edge
        scan(6'b001110, so);
        @(posedge clk); #2 upd = 1'b1;
        #3;
        chk("R4 before falling edge", {pin_oe, pin_out}, 8'b1010_0110);
        @(negedge clk); #2;
        chk("R4 after falling edge", {pin_oe, pin_out}, 8'b0010_1110);
        @(posedge clk); #2 upd = 1'b0;
        chk("R7 core_in under extest", {4'b0, core_in}, {4'b0, pin_in});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule